// File: doc/BRIEF.md
# Hashed MAC Address Table with Aging

This block is the address engine of a small Ethernet switch. It keeps one table of station addresses, each tied to the switch port it was last seen on. A destination lookup can be issued as soon as the destination address of a frame has been captured, before the frame ends. One cycle later the block reports whether the address was found, which port it belongs to, and a forwarding mask. A miss gives a mask that floods every port except the one the frame arrived on. A hit whose port equals the arrival port gives an empty mask, so the local frame is filtered.

A learn request writes a source address and its arrival port once a good unicast frame has been received in full. The same request, with a static flag raised, loads entries at configuration time. The table index is a selectable hash of the 48-bit address: the low address bits, or an XOR fold of the whole address. Learned (dynamic) entries carry an age bit. A background sweep visits every slot once per half aging period and uses only cycles in which no request is served. Each pass marks dynamic entries old, or removes those already marked. Static entries are never aged out and cannot be displaced by learning.

Top module: `macTable`

## Requirements
- R1: After reset every slot is empty: lookupValid is low and any lookup reports a miss.
- R2: A lookup requested in one cycle is answered in the next cycle with lookupValid high. lookupHit is high only when the indexed slot is valid and its stored 48-bit address equals the looked-up address in every bit, and lookupPort then gives the stored port.
- R3: With hashSel low the slot index is address bits [IDX_W-1:0]. With hashSel high, index bit k is the XOR of every address bit i with i mod IDX_W equal to k.
- R4: A learn writes the address and port as a valid entry. Learning an address already present on a different port replaces the stored port.
- R5: A dynamic learn (learnStatic low) replaces any dynamic occupant of its slot, but it is ignored when the slot holds a valid static entry. A static learn always writes its slot.
- R6: The forwarding mask has NPORTS bits, bit p standing for port p. On a hit to a port other than lookupSrcPort it has only the bit of the stored port set. On a hit to lookupSrcPort it is all zero. On a miss it has every bit set except the bit of lookupSrcPort.
- R7: A sweep pass starts every agePeriodHalf cycles. A dynamic entry that is neither learned nor relearned survives the first pass that visits it and is removed by the second.
- R8: Relearning an address clears its age mark, so an entry relearned more often than once per agePeriodHalf cycles is never removed.
- R9: Static entries are never removed by the sweep.
- R10: When agePeriodHalf is zero no sweep runs and dynamic entries stay indefinitely.
- R11: Lookups take the table before learns, and both take it before the sweep, so a lookup issued every cycle is answered every cycle. A learn issued in the same cycle as a lookup is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hashSel | input | 1 | 0: low-bit index, 1: XOR-folded index |
| agePeriodHalf | input | TIMER_W | Cycles between sweep pass starts; 0 disables aging |
| lookupReq | input | 1 | Destination lookup request |
| lookupMac | input | 48 | Destination address to look up |
| lookupSrcPort | input | 3 | Arrival port of the frame being looked up |
| learnReq | input | 1 | Learn request |
| learnMac | input | 48 | Source address to learn |
| learnPort | input | 3 | Port to store with the address |
| learnStatic | input | 1 | Write as a static entry |
| lookupValid | output | 1 | Lookup result present this cycle |
| lookupHit | output | 1 | Lookup found the address |
| lookupPort | output | 3 | Stored port on a hit, zero on a miss |
| lookupMask | output | NPORTS | Forwarding port mask |

## Verification
The bench builds the block with IDX_W set to 4, which gives a 16-slot table. Two addresses that share their low nibble collide under the low-bit hash, so slot conflicts and static protection can be set up with short constant addresses. The same 16 slots make each sweep pass only 16 idle cycles long. With agePeriodHalf driven to 50 cycles, survival after one pass, removal after two, refresh by relearning and starvation under back-to-back lookups all fit in a few hundred cycles. NPORTS keeps its default of five, so the flood mask is checked with a port bit set above the arrival port.

// File: rtl/macTablePkg.sv
package macTablePkg;

  localparam int MAC_W  = 48;
  localparam int PORT_W = 3;

  // One table slot
  typedef struct packed {
    logic              valid;
    logic              isStatic;
    logic              aged;
    logic [PORT_W-1:0] port;
    logic [MAC_W-1:0]  mac;
  } entry_t;

  // Control-to-datapath strobes: at most one is raised per cycle
  typedef struct packed {
    logic doLookup;
    logic doLearn;
    logic doSweep;
  } ctrlStrobes_t;

endpackage

// File: rtl/macTableCtrl.sv
module macTableCtrl
  import macTablePkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int TIMER_W = 36
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupReq,
  input  logic               learnReq,
  input  logic [TIMER_W-1:0] agePeriodHalf,
  output ctrlStrobes_t       strobes,
  output logic [IDX_W-1:0]   sweepIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic [TIMER_W-1:0] ageTimer;
  logic               sweepActive;
  logic               agingOn;
  logic               timerHit;

  assign agingOn  = (agePeriodHalf != '0);
  assign timerHit = agingOn && (ageTimer >= agePeriodHalf - TIMER_W'(1));

  // Fixed priority for the single table port
  always_comb begin
    strobes.doLookup = lookupReq;
    strobes.doLearn  = learnReq && !lookupReq;
    strobes.doSweep  = sweepActive && !lookupReq && !learnReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageTimer    <= '0;
      sweepActive <= 1'b0;
      sweepIdx    <= '0;
    end else begin
      if (!agingOn || timerHit) ageTimer <= '0;
      else                      ageTimer <= ageTimer + TIMER_W'(1);

      if (timerHit)
        sweepActive <= 1'b1;
      else if (strobes.doSweep && sweepIdx == LAST_IDX)
        sweepActive <= 1'b0;

      if (strobes.doSweep) sweepIdx <= sweepIdx + IDX_W'(1);
    end
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/macTableData.sv
module macTableData
  import macTablePkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int NPORTS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  sweepIdx,
  input  logic              hashSel,
  input  logic [MAC_W-1:0]  lookupMac,
  input  logic [PORT_W-1:0] lookupSrcPort,
  input  logic [MAC_W-1:0]  learnMac,
  input  logic [PORT_W-1:0] learnPort,
  input  logic              learnStatic,
  output logic              lookupValid,
  output logic              lookupHit,
  output logic [PORT_W-1:0] lookupPort,
  output logic [NPORTS-1:0] lookupMask
);

  localparam int ENTRIES = 1 << IDX_W;

  entry_t tbl [ENTRIES];

  function automatic logic [IDX_W-1:0] hashIdx(input logic [MAC_W-1:0] mac,
                                               input logic sel);
    logic [IDX_W-1:0] acc;
    acc = '0;
    if (sel) begin
      for (int i = 0; i < MAC_W; i++) acc[i % IDX_W] ^= mac[i];
    end else begin
      acc = mac[IDX_W-1:0];
    end
    return acc;
  endfunction

  logic [IDX_W-1:0]  lookupIdx, learnIdx;
  entry_t            rdEntry, learnSlot, sweepEntry;
  logic              rdHit, learnBlocked;
  logic [NPORTS-1:0] allButSrc, portBit, nextMask;

  assign lookupIdx    = hashIdx(lookupMac, hashSel);
  assign learnIdx     = hashIdx(learnMac, hashSel);
  assign rdEntry      = tbl[lookupIdx];
  assign learnSlot    = tbl[learnIdx];
  assign sweepEntry   = tbl[sweepIdx];
  assign rdHit        = rdEntry.valid && (rdEntry.mac == lookupMac);
  assign learnBlocked = !learnStatic && learnSlot.valid && learnSlot.isStatic;

  always_comb begin
    allButSrc = '1;
    portBit   = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (PORT_W'(p) == lookupSrcPort) allButSrc[p] = 1'b0;
      if (PORT_W'(p) == rdEntry.port)  portBit[p]   = 1'b1;
    end
    if (!rdHit)                          nextMask = allButSrc;
    else if (rdEntry.port == lookupSrcPort) nextMask = '0;
    else                                 nextMask = portBit;
  end

  // Lookup result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lookupValid <= 1'b0;
      lookupHit   <= 1'b0;
      lookupPort  <= '0;
      lookupMask  <= '0;
    end else begin
      lookupValid <= strobes.doLookup;
      lookupHit   <= strobes.doLookup && rdHit;
      lookupPort  <= (strobes.doLookup && rdHit) ? rdEntry.port : '0;
      lookupMask  <= strobes.doLookup ? nextMask : '0;
    end
  end

  // Table writes: learn, or one sweep step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (strobes.doLearn && !learnBlocked) begin
      tbl[learnIdx] <= '{valid: 1'b1, isStatic: learnStatic, aged: 1'b0,
                         port: learnPort, mac: learnMac};
    end else if (strobes.doSweep && sweepEntry.valid && !sweepEntry.isStatic) begin
      if (sweepEntry.aged) tbl[sweepIdx].valid <= 1'b0;
      else                 tbl[sweepIdx].aged  <= 1'b1;
    end
  end

  // R9
  static_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doSweep && sweepEntry.valid && sweepEntry.isStatic)
      |=> tbl[$past(sweepIdx)].valid);

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupHit |-> lookupValid);

  // R6
  mask_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doLookup && !rdHit && lookupSrcPort < PORT_W'(NPORTS))
      |=> $countones(lookupMask) == NPORTS - 1);

endmodule

// File: rtl/macTable.sv
module macTable
  import macTablePkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int TIMER_W = 36,
  parameter int NPORTS  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hashSel,
  input  logic [TIMER_W-1:0] agePeriodHalf,
  input  logic               lookupReq,
  input  logic [47:0]        lookupMac,
  input  logic [2:0]         lookupSrcPort,
  input  logic               learnReq,
  input  logic [47:0]        learnMac,
  input  logic [2:0]         learnPort,
  input  logic               learnStatic,
  output logic               lookupValid,
  output logic               lookupHit,
  output logic [2:0]         lookupPort,
  output logic [NPORTS-1:0]  lookupMask
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] sweepIdx;

  macTableCtrl #(.IDX_W(IDX_W), .TIMER_W(TIMER_W)) uCtrl (
    .clk, .rstN, .lookupReq, .learnReq, .agePeriodHalf,
    .strobes, .sweepIdx
  );

  macTableData #(.IDX_W(IDX_W), .NPORTS(NPORTS)) uData (
    .clk, .rstN, .strobes, .sweepIdx, .hashSel,
    .lookupMac, .lookupSrcPort, .learnMac, .learnPort, .learnStatic,
    .lookupValid, .lookupHit, .lookupPort, .lookupMask
  );

  // R2
  lookup_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> lookupValid);

endmodule

// File: tb/tb_macTable.sv
module tb_macTable;

  localparam int IDX_W   = 4;
  localparam int TIMER_W = 36;
  localparam int NPORTS  = 5;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               hashSel = 1'b0;
  logic [TIMER_W-1:0] agePeriodHalf = '0;
  logic               lookupReq = 1'b0;
  logic [47:0]        lookupMac = '0;
  logic [2:0]         lookupSrcPort = '0;
  logic               learnReq = 1'b0;
  logic [47:0]        learnMac = '0;
  logic [2:0]         learnPort = '0;
  logic               learnStatic = 1'b0;
  logic               lookupValid, lookupHit;
  logic [2:0]         lookupPort;
  logic [NPORTS-1:0]  lookupMask;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic              gotValid, gotHit;
  logic [2:0]        gotPort;
  logic [NPORTS-1:0] gotMask;

  macTable #(.IDX_W(IDX_W), .TIMER_W(TIMER_W), .NPORTS(NPORTS)) dut (
    .clk, .rstN, .hashSel, .agePeriodHalf,
    .lookupReq, .lookupMac, .lookupSrcPort,
    .learnReq, .learnMac, .learnPort, .learnStatic,
    .lookupValid, .lookupHit, .lookupPort, .lookupMask
  );

  always #2 clk = ~clk;

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      finishRun();
    end
  end

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  task automatic learn(input logic [47:0] mac, input logic [2:0] port,
                       input logic isStatic);
    @(negedge clk);
    learnReq = 1'b1; learnMac = mac; learnPort = port; learnStatic = isStatic;
    @(negedge clk);
    learnReq = 1'b0; learnStatic = 1'b0;
  endtask

  task automatic lookup(input logic [47:0] mac, input logic [2:0] src);
    @(negedge clk);
    lookupReq = 1'b1; lookupMac = mac; lookupSrcPort = src;
    @(negedge clk);
    lookupReq = 1'b0;
    gotValid = lookupValid; gotHit = lookupHit;
    gotPort = lookupPort; gotMask = lookupMask;
  endtask

  task automatic expectHit(input logic [47:0] mac, input logic [2:0] port,
                           input string req);
    lookup(mac, 3'd0);
    check(gotValid && gotHit && gotPort == port, req,
          {gotValid, gotHit, gotPort}, {1'b1, 1'b1, port});
  endtask

  task automatic expectMiss(input logic [47:0] mac, input string req);
    lookup(mac, 3'd0);
    check(gotValid && !gotHit, req, {gotValid, gotHit}, 2'b10);
  endtask

  // R1
  task automatic testReset();
    resetDut();
    @(negedge clk);
    check(lookupValid == 1'b0, "R1 valid idle", lookupValid, 0);
    expectMiss(48'h0000_0000_0003, "R1 empty after reset");
  endtask

  // R2 R4 R6
  task automatic testBasic();
    resetDut();
    learn(48'h0000_0000_0003, 3'd4, 1'b0);
    expectHit(48'h0000_0000_0003, 3'd4, "R4 learn hit");
    expectMiss(48'h0001_0000_0003, "R2 partial match miss");
    learn(48'h0000_0000_0003, 3'd1, 1'b0);
    expectHit(48'h0000_0000_0003, 3'd1, "R4 port move");
    lookup(48'h0000_0000_0003, 3'd3);
    check(gotMask == 5'b00010, "R6 hit mask", gotMask, 5'b00010);
    lookup(48'h0000_0000_0003, 3'd1);
    check(gotHit && gotMask == 5'b00000, "R6 local filter", gotMask, 0);
    lookup(48'h0000_0000_0007, 3'd2);
    check(!gotHit && gotMask == 5'b11011, "R6 flood mask", gotMask, 5'b11011);
  endtask

  // R3
  task automatic testHash();
    resetDut();
    hashSel = 1'b0;
    learn(48'h0000_0000_0003, 3'd1, 1'b0);
    learn(48'h0000_0000_0013, 3'd2, 1'b0);
    expectMiss(48'h0000_0000_0003, "R3 low-bit collision");
    expectHit(48'h0000_0000_0013, 3'd2, "R3 low-bit newer");
    resetDut();
    hashSel = 1'b1;
    learn(48'h0000_0000_0003, 3'd1, 1'b0);
    learn(48'h0000_0000_0013, 3'd2, 1'b0);
    expectHit(48'h0000_0000_0003, 3'd1, "R3 xor no collision");
    learn(48'h0000_0000_0030, 3'd3, 1'b0);
    expectMiss(48'h0000_0000_0003, "R3 xor collision");
    expectHit(48'h0000_0000_0030, 3'd3, "R3 xor newer");
    hashSel = 1'b0;
  endtask

  // R5
  task automatic testStatic();
    resetDut();
    learn(48'h0000_0000_0005, 3'd2, 1'b1);
    learn(48'h0000_0000_0015, 3'd3, 1'b0);
    expectMiss(48'h0000_0000_0015, "R5 dynamic blocked");
    expectHit(48'h0000_0000_0005, 3'd2, "R5 static kept");
    learn(48'h0000_0000_0015, 3'd3, 1'b1);
    expectHit(48'h0000_0000_0015, 3'd3, "R5 static overwrite");
  endtask

  // R7 R8 R9 R10
  task automatic testAging();
    resetDut();
    agePeriodHalf = 0;
    learn(48'h0000_0000_0002, 3'd2, 1'b0);
    idle(300);
    expectHit(48'h0000_0000_0002, 3'd2, "R10 no aging when zero");
    resetDut();
    agePeriodHalf = 50;
    learn(48'h0000_0000_0004, 3'd1, 1'b1);
    learn(48'h0000_0000_0006, 3'd3, 1'b0);
    idle(40);
    expectHit(48'h0000_0000_0006, 3'd3, "R7 survives one pass");
    idle(200);
    expectMiss(48'h0000_0000_0006, "R7 removed after two passes");
    expectHit(48'h0000_0000_0004, 3'd1, "R9 static not aged");
    for (int k = 0; k < 8; k++) begin
      learn(48'h0000_0000_0008, 3'd4, 1'b0);
      idle(25);
    end
    expectHit(48'h0000_0000_0008, 3'd4, "R8 refresh keeps entry");
    agePeriodHalf = 0;
  endtask

  // R11
  task automatic testPriority();
    int bad;
    resetDut();
    agePeriodHalf = 50;
    learn(48'h0000_0000_0009, 3'd2, 1'b0);
    bad = 0;
    @(negedge clk);
    lookupReq = 1'b1; lookupMac = 48'h0000_0000_0009; lookupSrcPort = 3'd0;
    for (int k = 0; k < 160; k++) begin
      @(negedge clk);
      if (!(lookupValid && lookupHit && lookupPort == 3'd2)) bad = bad + 1;
    end
    lookupReq = 1'b0;
    check(bad == 0, "R11 lookup every cycle", bad, 0);
    agePeriodHalf = 0;
    @(negedge clk);
    lookupReq = 1'b1; lookupMac = 48'h0000_0000_0009;
    learnReq = 1'b1; learnMac = 48'h0000_0000_000A; learnPort = 3'd3;
    @(negedge clk);
    lookupReq = 1'b0; learnReq = 1'b0;
    check(lookupValid && lookupHit, "R11 lookup served", {lookupValid, lookupHit}, 2'b11);
    expectMiss(48'h0000_0000_000A, "R11 colliding learn dropped");
  endtask

  initial begin
    testReset();
    testBasic();
    testHash();
    testStatic();
    testAging();
    testPriority();
    finishRun();
  end

endmodule